// File: doc/BRIEF.md
# Dual-Address I2C Slave Register Port

This block is an I2C-bus slave that sits in front of two internal register banks. Both banks share one SCL/SDA pin pair and answer to two different 7-bit addresses. In both addresses the upper five bits are the constant `00100`, and the lower two bits select the device. The converter bank takes its two select bits from a pair of strap inputs and accepts writes only. The digital-interface bank always uses select bits `00`, and it accepts both writes and auto-continuing reads.

SCL and SDA arrive as oversampled levels. They pass through a synchronizer, and START and STOP conditions are found from the synchronized levels. The block drives SDA only by pulling it low, through `sda_oe`. After the address byte, the first byte written is stored as the register sub-address. Each data byte after that, in a write or a read, uses the current sub-address and then increments it. Register writes leave the block as single-cycle strobes with a shared address and data bus. Register reads take data combinationally from the digital-interface bank, based on `dir_rd_addr`.

Top module: `dual_addr_i2c_port`

## Requirements
- R1: An address byte of `{00100, strap_sel, 0}` with `strap_sel` not equal to 00 is acknowledged. SDA is held low from the falling SCL edge after bit 8 until the next falling edge, so it is low for the whole high phase of pulse 9.
- R2: When `strap_sel` = 00, the converter bank cannot be addressed. Address bytes with select bits 01, 10 or 11 get no acknowledge, and `cnv_wr_en` never fires.
- R3: Address `0010000` is acknowledged for writes (R/W = 0) and for reads (R/W = 1), whatever the value of `strap_sel`.
- R4: A read (R/W = 1) sent to the converter address gets no acknowledge. SDA stays released for the rest of that transfer, and no read strobe is issued.
- R5: In a write, the first byte after the address is acknowledged and becomes the sub-address. It does not produce a write strobe.
- R6: Each later written byte is acknowledged. It produces exactly one single-cycle strobe to the addressed bank (`cnv_wr_en` or `dir_wr_en`) with `wr_addr` equal to the sub-address and `wr_data` equal to the byte. The sub-address then increases by one.
- R7: In a read, the byte at the sub-address is sent MSB first. While the master acknowledges, the following bytes come from consecutive sub-addresses, with one `dir_rd_en` pulse per byte.
- R8: After a read byte that the master does not acknowledge, SDA stays released and no further read strobes are issued until the next START or STOP.
- R9: A START, including one that arrives in the middle of a byte, drops the partial byte. Reception then restarts with a new address byte.
- R10: An address byte that matches neither bank gets no acknowledge. The data bytes that follow it cause no strobes.
- R11: After reset, `sda_oe` is low and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | When 1, pull SDA low |
| strap_sel | input | 2 | Device-select straps for the converter bank |
| cnv_wr_en | output | 1 | Converter bank write strobe |
| dir_wr_en | output | 1 | Digital-interface bank write strobe |
| wr_addr | output | 8 | Write register sub-address |
| wr_data | output | 8 | Write data |
| dir_rd_en | output | 1 | Digital-interface bank read strobe |
| dir_rd_addr | output | 8 | Read sub-address (current pointer) |
| dir_rd_data | input | 8 | Combinational read data for `dir_rd_addr` |

## Verification
Most internal faults show up within one byte time. A wrong address decode or a wrong bank select changes the acknowledge bit on pulse 9, or it sends the next strobe to the wrong enable. A wrong sub-address pointer shows in `wr_addr` on the first data strobe, or in the first byte returned by a read. A bit counter that is off by one moves the acknowledge slot, and this corrupts every following bit. A missed NACK or a missed START leaves the state machine driving SDA or strobing on the next clock pulses, and the bus shows this at once.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;
  localparam int BYTE_W = 8;
  localparam logic [4:0] ID_HIGH = 5'b00100;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WBYTE, ST_WACK, ST_RBYTE, ST_RACK, ST_HOLD
  } i2cp_state_e;

  typedef enum logic {BANK_CNV = 1'b0, BANK_DIR = 1'b1} bank_e;

  typedef struct packed {
    logic  hit;
    logic  ack;
    logic  rd;
    bank_e bank;
  } dec_t;

  function automatic logic [6:0] dev_id(input logic [1:0] sel);
    return {ID_HIGH, sel};
  endfunction

  // Decode the first byte after START against both bank addresses.
  function automatic dec_t decode_first(input logic [BYTE_W-1:0] fb,
                                        input logic [1:0] strap);
    dec_t d;
    d = '0;
    d.rd = fb[0];
    d.bank = BANK_DIR;
    if (fb[7:1] == dev_id(2'b00)) begin
      d.hit = 1'b1;
      d.ack = 1'b1;
    end else if (strap != 2'b00 && fb[7:1] == dev_id(strap)) begin
      d.hit  = 1'b1;
      d.bank = BANK_CNV;
      d.ack  = ~fb[0];
    end
    return d;
  endfunction
endpackage

// File: rtl/i2cp_line_mon.sv
module i2cp_line_mon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign bus_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2cp_engine.sv
module i2cp_engine
  import i2cp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic [1:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              cnv_wr_en,
  output logic              dir_wr_en,
  output logic              dir_rd_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_addr
);
  i2cp_state_e       state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg, ptr;
  bank_e             bank;
  logic              is_rd, first_wr, m_ack;
  dec_t              dec;
  logic              byte_done, bus_evt;

  assign dec       = decode_first(shreg, strap);
  assign byte_done = scl_fall && bit_cnt == 4'd8;
  assign bus_evt   = bus_start | bus_stop;
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_cnt <= '0; shreg <= '0; ptr <= '0;
      bank <= BANK_DIR; is_rd <= 1'b0; first_wr <= 1'b0; m_ack <= 1'b0;
      sda_oe <= 1'b0; cnv_wr_en <= 1'b0; dir_wr_en <= 1'b0; dir_rd_en <= 1'b0;
      wr_addr <= '0; wr_data <= '0;
    end else begin
      cnv_wr_en <= 1'b0;
      dir_wr_en <= 1'b0;
      dir_rd_en <= 1'b0;
      if (bus_stop) begin
        state <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (bus_start) begin
        state <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WBYTE: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_lvl};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (byte_done) begin
              if (state == ST_ADDR) begin
                if (dec.hit && dec.ack) begin
                  sda_oe <= 1'b1;
                  bank <= dec.bank;
                  is_rd <= dec.rd;
                  state <= ST_AACK;
                end else begin
                  state <= ST_HOLD;
                end
              end else begin
                sda_oe <= 1'b1;
                state <= ST_WACK;
                if (first_wr) begin
                  ptr <= shreg;
                  first_wr <= 1'b0;
                end else begin
                  cnv_wr_en <= (bank == BANK_CNV);
                  dir_wr_en <= (bank == BANK_DIR);
                  wr_addr <= ptr;
                  wr_data <= shreg;
                  ptr <= ptr + 1'b1;
                end
              end
            end
          end
          ST_AACK, ST_RACK: begin
            if (state == ST_RACK && scl_rise) m_ack <= ~sda_lvl;
            if (scl_fall) begin
              bit_cnt <= '0;
              if (state == ST_AACK && !is_rd) begin
                sda_oe <= 1'b0;
                first_wr <= 1'b1;
                state <= ST_WBYTE;
              end else if (state == ST_AACK || m_ack) begin
                dir_rd_en <= 1'b1;
                sda_oe <= ~rd_data[BYTE_W-1];
                shreg <= {rd_data[BYTE_W-2:0], 1'b0};
                ptr <= ptr + 1'b1;
                state <= ST_RBYTE;
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bit_cnt <= '0;
              state <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_fall) begin
              bit_cnt <= bit_cnt + 4'd1;
              if (bit_cnt == 4'd7) begin
                sda_oe <= 1'b0;
                state <= ST_RACK;
              end else begin
                sda_oe <= ~shreg[BYTE_W-1];
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) && !$past(bus_evt) |-> !$past(scl_lvl));
  // R6
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cnv_wr_en, dir_wr_en, dir_rd_en}));
  // R6
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_wr_en || dir_wr_en) |=> !(cnv_wr_en || dir_wr_en));
  // R2
  cnv_strap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_wr_en |-> strap != 2'b00);
  // R4
  cnv_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rd_en |-> bank == BANK_DIR);
  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD || state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/dual_addr_i2c_port.sv
module dual_addr_i2c_port #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] strap_sel,
  output logic       cnv_wr_en,
  output logic       dir_wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       dir_rd_en,
  output logic [7:0] dir_rd_addr,
  input  logic [7:0] dir_rd_data
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

  i2cp_line_mon #(.STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
  );

  i2cp_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .strap(strap_sel), .rd_data(dir_rd_data),
    .sda_oe(sda_oe), .cnv_wr_en(cnv_wr_en), .dir_wr_en(dir_wr_en),
    .dir_rd_en(dir_rd_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(dir_rd_addr)
  );
endmodule

// File: tb/dual_addr_i2c_port_test.sv
module dual_addr_i2c_port_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic sda_oe, cnv_wr_en, dir_wr_en, dir_rd_en;
  logic [7:0] wr_addr, wr_data, dir_rd_addr, dir_rd_data;
  logic sda_bus;
  logic [7:0] mem [256];
  int vectors = 0, miscompares = 0, rd_cnt = 0;
  bit done = 0;

  typedef struct {
    logic       bnk;
    logic [7:0] ad;
    logic [7:0] dt;
    string      req;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign dir_rd_data = mem[dir_rd_addr];

  dual_addr_i2c_port uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_sel(strap), .cnv_wr_en(cnv_wr_en), .dir_wr_en(dir_wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dir_rd_en(dir_rd_en),
    .dir_rd_addr(dir_rd_addr), .dir_rd_data(dir_rd_data)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 13 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic push(input logic b, input logic [7:0] a, input logic [7:0] d, input string req);
    exp_t e;
    e.bnk = b; e.ad = a; e.dt = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: pop expected write strobes and compare.
  always @(negedge clk) begin
    if (rst_n) begin
      if (cnv_wr_en || dir_wr_en) begin
        if (exp_q.size() == 0) begin
          chk("R6 unexpected strobe", {15'd0, dir_wr_en, wr_addr, wr_data}, 32'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, {15'd0, dir_wr_en, wr_addr, wr_data}, {15'd0, e.bnk, e.ad, e.dt});
        end
        if (dir_wr_en) mem[wr_addr] = wr_data;
      end
      if (dir_rd_en) rd_cnt++;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic put_byte(input logic [7:0] d, output logic acked);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(d[i], r);
    clk_bit(1'b1, r);
    acked = ~r;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      d[i] = r;
    end
    clk_bit(~give_ack, r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int rc;
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    repeat (10) @(negedge clk);
    // R11 reset state
    chk("R11 oe", {31'd0, sda_oe}, 0);
    chk("R11 strobes", {29'd0, cnv_wr_en, dir_wr_en, dir_rd_en}, 0);
    rst_n = 1'b1;
    wq();

    // R1 R5 R6 converter write with strap 10 -> address 0x12
    bus_start();
    put_byte(8'h24, a); chk("R1 cnv addr ack", {31'd0, a}, 1);
    put_byte(8'h40, a); chk("R5 subaddr ack", {31'd0, a}, 1);
    push(1'b0, 8'h40, 8'hA5, "R6 cnv wr0");
    put_byte(8'hA5, a); chk("R6 data ack", {31'd0, a}, 1);
    push(1'b0, 8'h41, 8'h5A, "R6 cnv wr1");
    put_byte(8'h5A, a); chk("R6 data ack2", {31'd0, a}, 1);
    bus_stop();

    // R4 converter read refused
    rc = rd_cnt;
    bus_start();
    put_byte(8'h25, a); chk("R4 read nack", {31'd0, a}, 0);
    get_byte(1'b1, d); chk("R4 sda released", {24'd0, d}, 32'hFF);
    chk("R4 no rd strobe", rd_cnt, rc);
    bus_stop();

    // R2 strap 00 makes converter unaddressable
    strap = 2'b00;
    for (int k = 1; k < 4; k++) begin
      bus_start();
      put_byte({5'b00100, 2'(k), 1'b0}, a); chk("R2 no ack", {31'd0, a}, 0);
      put_byte(8'h01, a);
      put_byte(8'h02, a);
      bus_stop();
    end

    // R10 unrelated address
    bus_start();
    put_byte(8'hAA, a); chk("R10 no ack", {31'd0, a}, 0);
    put_byte(8'h10, a); put_byte(8'h33, a);
    chk("R10 sda released", {31'd0, a}, 0);
    bus_stop();

    // R3 R6 digital-interface bank write (strap still 00)
    bus_start();
    put_byte(8'h20, a); chk("R3 dir write ack", {31'd0, a}, 1);
    put_byte(8'h20, a);
    push(1'b1, 8'h20, 8'h11, "R6 dir wr0");
    put_byte(8'h11, a);
    push(1'b1, 8'h21, 8'h22, "R6 dir wr1");
    put_byte(8'h22, a);
    push(1'b1, 8'h22, 8'h33, "R6 dir wr2");
    put_byte(8'h33, a);
    bus_stop();
    strap = 2'b11;

    // R3 R7 R9 R8 read with repeated start
    rc = rd_cnt;
    bus_start();
    put_byte(8'h20, a);
    put_byte(8'h30, a);
    bus_start();
    put_byte(8'h21, a); chk("R3 dir read ack", {31'd0, a}, 1);
    get_byte(1'b1, d); chk("R7 byte0", {24'd0, d}, {24'd0, init_val(8'h30)});
    get_byte(1'b1, d); chk("R7 byte1", {24'd0, d}, {24'd0, init_val(8'h31)});
    get_byte(1'b0, d); chk("R7 byte2", {24'd0, d}, {24'd0, init_val(8'h32)});
    get_byte(1'b1, d); chk("R8 released after nack", {24'd0, d}, 32'hFF);
    chk("R8 rd strobes", rd_cnt - rc, 3);
    bus_stop();

    // R7 read back written data
    bus_start();
    put_byte(8'h20, a); put_byte(8'h20, a);
    bus_start();
    put_byte(8'h21, a);
    get_byte(1'b1, d); chk("R7 readback0", {24'd0, d}, 32'h11);
    get_byte(1'b0, d); chk("R7 readback1", {24'd0, d}, 32'h22);
    bus_stop();

    // R9 START in the middle of a data byte
    bus_start();
    put_byte(8'h20, a); put_byte(8'h50, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
    bus_start();
    put_byte(8'h20, a); chk("R9 restart addr ack", {31'd0, a}, 1);
    put_byte(8'h60, a);
    push(1'b1, 8'h60, 8'h77, "R9 after restart");
    put_byte(8'h77, a);
    bus_stop();

    wq();
    chk("R6 all strobes seen", exp_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule